// File: doc/BRIEF.md
# Activity-Qualified Data Bus Output Guard

This block sits between a host bus and the 8-bit data pins of a peripheral. It keeps the data pins in high impedance until the device at the other end has shown that it behaves like a live bus master. Until then the peripheral cannot contend with whatever else might be wired to those pins. The block watches the host clock, the read/write strobe, the active-low select and a group of address lines. All four are brought into the local clock domain first. It counts transitions on them, and it arms only when the clock and the strobe have both toggled often enough, at least one address change has been seen, and the select has stayed high the whole time.

Once armed, the block enables the data pins during host read cycles that select the peripheral: host clock high, select low, strobe high. It presents the internal read byte during those cycles and withdraws drive when the host clock falls. Two timers guard the armed state. If the host clock is held high too long, drive is cut and the block de-arms. If the host clock stops toggling, the block also de-arms and must qualify again.

Top module: `bus_drive_guard`

## Requirements
- R1: The data output enable is high only when the block is armed, the synchronised host clock is high, the synchronised select is low and the synchronised strobe is high (read). While it is high, the driven byte equals the read-data input.
- R2: After reset the output enable is low, the driven byte is 0x00 and the armed flag is low. No drive occurs while unarmed, whatever the host inputs do, and the driven byte is 0x00 whenever the enable is low.
- R3: The block arms only after at least EDGE_THRESH transitions (rising and falling both count) on the host clock and at least EDGE_THRESH transitions on the strobe, with the select high.
- R4: Before arming, any transition on the select, or a low select level, clears all qualification progress.
- R5: At least one change on any address-activity line is required before arming.
- R6: A driven read cycle ends when the synchronised host clock falls. The enable is low in the cycle that the fall is seen.
- R7: If WINDOW_RISES rising host-clock edges pass since the last restart without qualification, all qualification progress is cleared and counting starts again.
- R8: A select held high never enables drive, even when armed. A floating select is pulled high at the pad and so behaves as deselected.
- R9: If the synchronised host clock stays high for STALL_CLKS local clocks while armed, drive is withdrawn and the block de-arms.
- R10: If no host-clock transition is seen for IDLE_CLKS local clocks while armed, the block de-arms and must qualify again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_clk_i | input | 1 | Raw host bus clock |
| host_rnw_i | input | 1 | Raw host read/write strobe, 1 = read |
| host_sel_n_i | input | 1 | Raw active-low select, pulled up at the pad |
| host_addr_i | input | ADDR_W | Raw address-activity lines |
| rd_byte_i | input | 8 | Internal byte to present on reads |
| bus_oe_o | output | 1 | Data pin output enable |
| bus_data_o | output | 8 | Byte presented on the data pins |
| armed_o | output | 1 | High while the block is armed |

## Verification
The bench builds the block with EDGE_THRESH = 8, WINDOW_RISES = 10, STALL_CLKS = 16 and IDLE_CLKS = 48, with the host clock half period set to four local clocks. These small values bring every path within a few hundred cycles. The test covers arming, progress being cleared by select activity, the window restart, the stall cut-off and the idle de-arm, along with read, write and deselected cycles. It also checks the negative cases just below each threshold: too few transitions, no address activity, and a window restart that discards earlier host-clock counts.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

    typedef enum logic {
        GD_IDLE  = 1'b0,
        GD_ARMED = 1'b1
    } guard_st_e;

endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/bg_qualifier.sv
module bg_qualifier #(
    parameter int EDGE_THRESH  = 32,
    parameter int WINDOW_RISES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sel_n_i,
    input  logic sel_edge_i,
    input  logic hclk_edge_i,
    input  logic hclk_rise_i,
    input  logic rnw_edge_i,
    input  logic addr_edge_i,
    output logic qual_o
);
    localparam int CW = $clog2(EDGE_THRESH + 1);
    localparam int WW = $clog2(WINDOW_RISES + 1);
    localparam logic [CW-1:0] THR = CW'(EDGE_THRESH);
    localparam logic [WW-1:0] WIN = WW'(WINDOW_RISES);

    typedef struct packed {
        logic [CW-1:0] hclk_cnt;
        logic [CW-1:0] rnw_cnt;
        logic [WW-1:0] win_cnt;
        logic          addr_seen;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     met;

    assign met    = (st_q.hclk_cnt >= THR) && (st_q.rnw_cnt >= THR) &&
                    st_q.addr_seen && sel_n_i;
    assign qual_o = met;

    always_comb begin
        st_d = st_q;
        if (clear_i || sel_edge_i || !sel_n_i) begin
            st_d = '0;
        end else begin
            if (hclk_edge_i && (st_q.hclk_cnt < THR))
                st_d.hclk_cnt = st_q.hclk_cnt + 1'b1;
            if (rnw_edge_i && (st_q.rnw_cnt < THR))
                st_d.rnw_cnt = st_q.rnw_cnt + 1'b1;
            if (addr_edge_i)
                st_d.addr_seen = 1'b1;
            if (hclk_rise_i) begin
                if ((st_q.win_cnt + 1'b1 >= WIN) && !met)
                    st_d = '0;
                else if (st_q.win_cnt < WIN)
                    st_d.win_cnt = st_q.win_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a select transition seen while counting wipes progress
    p_sel_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_edge_i |=> (st_q.hclk_cnt == '0) && (st_q.rnw_cnt == '0) && !st_q.addr_seen);

    // R3: counters never pass the threshold
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hclk_cnt <= THR) && (st_q.rnw_cnt <= THR));

    // R7: window counter stays inside its limit
    p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win_cnt <= WIN);
endmodule

// File: rtl/bg_timeout.sv
module bg_timeout #(
    parameter int STALL_CLKS = 64,
    parameter int IDLE_CLKS  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic hclk_i,
    input  logic hclk_edge_i,
    output logic stall_o,
    output logic idle_o
);
    localparam int SW = $clog2(STALL_CLKS + 1);
    localparam int IW = $clog2(IDLE_CLKS + 1);
    localparam logic [SW-1:0] SLIM = SW'(STALL_CLKS);
    localparam logic [IW-1:0] ILIM = IW'(IDLE_CLKS);

    typedef struct packed {
        logic [SW-1:0] stall_cnt;
        logic [IW-1:0] idle_cnt;
    } to_st_t;

    to_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i && hclk_i) begin
            if (st_q.stall_cnt < SLIM) st_d.stall_cnt = st_q.stall_cnt + 1'b1;
        end else begin
            st_d.stall_cnt = '0;
        end
        if (!active_i || hclk_edge_i) begin
            st_d.idle_cnt = '0;
        end else if (st_q.idle_cnt < ILIM) begin
            st_d.idle_cnt = st_q.idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_o = (st_q.stall_cnt >= SLIM);
    assign idle_o  = (st_q.idle_cnt >= ILIM);

    // R9: stall counter saturates at its limit
    p_stall_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stall_cnt <= SLIM);

    // R10: idle counter restarts on host clock activity
    p_idle_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hclk_edge_i |=> (st_q.idle_cnt == '0));
endmodule

// File: rtl/bus_drive_guard.sv
module bus_drive_guard
    import bus_guard_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int EDGE_THRESH  = 32,
    parameter int WINDOW_RISES = 300,
    parameter int STALL_CLKS   = 64,
    parameter int IDLE_CLKS    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_clk_i,
    input  logic              host_rnw_i,
    input  logic              host_sel_n_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [7:0]        rd_byte_i,
    output logic              bus_oe_o,
    output logic [7:0]        bus_data_o,
    output logic              armed_o
);
    localparam int HW = 3 + ADDR_W;

    typedef struct packed {
        guard_st_e         st;
        logic              hclk_p;
        logic              rnw_p;
        logic              sel_n_p;
        logic [ADDR_W-1:0] addr_p;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [HW-1:0]     raw_w, syn_w;
    logic              hclk_s, rnw_s, sel_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic              hclk_edge, hclk_rise, hclk_fall, rnw_edge, sel_edge, addr_edge;
    logic              qual_w, stall_w, idle_w, armed_w;

    assign raw_w = {host_clk_i, host_rnw_i, host_sel_n_i, host_addr_i};

    bg_sync #(
        .W       (HW),
        .RST_VAL ({1'b0, 1'b0, 1'b1, {ADDR_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (syn_w)
    );

    assign {hclk_s, rnw_s, sel_n_s, addr_s} = syn_w;

    assign hclk_edge = hclk_s ^ top_q.hclk_p;
    assign hclk_rise = hclk_s & ~top_q.hclk_p;
    assign hclk_fall = ~hclk_s & top_q.hclk_p;
    assign rnw_edge  = rnw_s ^ top_q.rnw_p;
    assign sel_edge  = sel_n_s ^ top_q.sel_n_p;
    assign addr_edge = |(addr_s ^ top_q.addr_p);
    assign armed_w   = (top_q.st == GD_ARMED);

    bg_qualifier #(
        .EDGE_THRESH  (EDGE_THRESH),
        .WINDOW_RISES (WINDOW_RISES)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (armed_w),
        .sel_n_i     (sel_n_s),
        .sel_edge_i  (sel_edge),
        .hclk_edge_i (hclk_edge),
        .hclk_rise_i (hclk_rise),
        .rnw_edge_i  (rnw_edge),
        .addr_edge_i (addr_edge),
        .qual_o      (qual_w)
    );

    bg_timeout #(
        .STALL_CLKS (STALL_CLKS),
        .IDLE_CLKS  (IDLE_CLKS)
    ) u_to (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (armed_w),
        .hclk_i      (hclk_s),
        .hclk_edge_i (hclk_edge),
        .stall_o     (stall_w),
        .idle_o      (idle_w)
    );

    always_comb begin
        top_d         = top_q;
        top_d.hclk_p  = hclk_s;
        top_d.rnw_p   = rnw_s;
        top_d.sel_n_p = sel_n_s;
        top_d.addr_p  = addr_s;
        unique case (top_q.st)
            GD_IDLE:  if (qual_w) top_d.st = GD_ARMED;
            GD_ARMED: if (stall_w || idle_w) top_d.st = GD_IDLE;
            default:  top_d.st = GD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.st      <= GD_IDLE;
            top_q.hclk_p  <= 1'b0;
            top_q.rnw_p   <= 1'b0;
            top_q.sel_n_p <= 1'b1;
            top_q.addr_p  <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_oe_o   = armed_w && hclk_s && !sel_n_s && rnw_s && !stall_w;
    assign bus_data_o = bus_oe_o ? rd_byte_i : 8'h00;
    assign armed_o    = armed_w;

    // R3: arming is always preceded by a qualifier pass
    p_arm_needs_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_w) |-> $past(qual_w));

    // R6: the cycle in which the host clock fall is seen carries no drive
    p_release_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hclk_fall |-> !bus_oe_o);

    // R9: a stall while armed leads to de-arming on the next cycle
    p_dearm_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && stall_w) |=> !armed_w);

    // R10: idle timeout while armed leads to de-arming
    p_dearm_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && idle_w) |=> !armed_w);

    // R2: undriven pins present zero
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_data_o == 8'h00));
endmodule

// File: tb/tb_bus_drive_guard.sv
module tb_bus_drive_guard;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hclk_r = 1'b0;
    logic              rnw_r = 1'b1;
    logic              sel_r = 1'b1;
    logic [ADDR_W-1:0] addr_r = '0;
    logic [7:0]        rd_r = 8'h00;
    logic              oe_w;
    logic [7:0]        data_w;
    logic              armed_w;

    always #4 clk = ~clk;

    bus_drive_guard #(
        .ADDR_W       (ADDR_W),
        .EDGE_THRESH  (8),
        .WINDOW_RISES (10),
        .STALL_CLKS   (16),
        .IDLE_CLKS    (48)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_clk_i   (hclk_r),
        .host_rnw_i   (rnw_r),
        .host_sel_n_i (sel_r),
        .host_addr_i  (addr_r),
        .rd_byte_i    (rd_r),
        .bus_oe_o     (oe_w),
        .bus_data_o   (data_w),
        .armed_o      (armed_w)
    );

    typedef struct {
        string      tag;
        logic       oe;
        logic [7:0] data;
        logic       armed;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // monitor: pops expectations and compares at a falling clock edge
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            @(negedge clk);
            begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (oe_w !== it.oe || data_w !== it.data || armed_w !== it.armed) begin
                    n_bad++;
                    $display("FAIL %s: got oe=%b data=%h armed=%b, want oe=%b data=%h armed=%b",
                             it.tag, oe_w, data_w, armed_w, it.oe, it.data, it.armed);
                end
            end
        end
    end

    task automatic expect_st(input string tag, input logic oe, input logic [7:0] d,
                             input logic arm);
        sb_item_t it;
        it.tag = tag; it.oe = oe; it.data = d; it.armed = arm;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic half(input logic ph, input bit trnw, input bit taddr);
        hclk_r = ph;
        if (trnw)  rnw_r = ~rnw_r;
        if (taddr) addr_r = addr_r + 1'b1;
        wait_clks(4);
    endtask

    task automatic cycles(input int n, input bit trnw, input bit taddr_first);
        for (int i = 0; i < n; i++) begin
            half(1'b1, trnw, taddr_first && (i == 0));
            half(1'b0, trnw, 1'b0);
        end
    endtask

    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        expect_st("R2 reset state", 1'b0, 8'h00, 1'b0);

        // select low with a read pattern while unarmed: no drive
        rd_r = 8'h5A; sel_r = 1'b0; hclk_r = 1'b1; rnw_r = 1'b1;
        wait_clks(6);
        expect_st("R2 no drive unarmed", 1'b0, 8'h00, 1'b0);
        hclk_r = 1'b0; sel_r = 1'b1;
        wait_clks(4);

        // enough clock and strobe transitions but no address change
        cycles(6, 1'b1, 1'b0);
        expect_st("R5 no address activity", 1'b0, 8'h00, 1'b0);
        addr_r = addr_r + 1'b1;
        wait_clks(5);
        expect_st("R3 R5 armed after address change", 1'b0, 8'h00, 1'b1);

        // read cycle
        rnw_r = 1'b1; rd_r = 8'hA5; sel_r = 1'b0; hclk_r = 1'b1;
        wait_clks(3);
        expect_st("R1 read drives", 1'b1, 8'hA5, 1'b1);
        hclk_r = 1'b0;
        wait_clks(2);
        expect_st("R6 release at clock fall", 1'b0, 8'h00, 1'b1);

        // write cycle
        rnw_r = 1'b0; hclk_r = 1'b1;
        wait_clks(4);
        expect_st("R1 write not driven", 1'b0, 8'h00, 1'b1);
        hclk_r = 1'b0;
        wait_clks(4);

        // deselected read
        rnw_r = 1'b1; sel_r = 1'b1; hclk_r = 1'b1;
        wait_clks(4);
        expect_st("R8 select high no drive", 1'b0, 8'h00, 1'b1);
        hclk_r = 1'b0;
        wait_clks(4);

        // second read value
        rd_r = 8'h3C; sel_r = 1'b0; hclk_r = 1'b1;
        wait_clks(3);
        expect_st("R1 read second byte", 1'b1, 8'h3C, 1'b1);
        hclk_r = 1'b0;
        wait_clks(4);

        // clock stuck high during a read
        hclk_r = 1'b1;
        wait_clks(30);
        expect_st("R9 stall releases and de-arms", 1'b0, 8'h00, 1'b0);
        hclk_r = 1'b0; sel_r = 1'b1;
        wait_clks(6);

        // too few transitions, then enough
        cycles(3, 1'b1, 1'b1);
        expect_st("R3 below threshold", 1'b0, 8'h00, 1'b0);
        cycles(2, 1'b1, 1'b0);
        expect_st("R3 threshold reached", 1'b0, 8'h00, 1'b1);

        // host clock stops
        wait_clks(80);
        expect_st("R10 idle de-arms", 1'b0, 8'h00, 1'b0);

        // select pulse wipes progress
        cycles(3, 1'b1, 1'b1);
        sel_r = 1'b0; wait_clks(4); sel_r = 1'b1; wait_clks(4);
        cycles(2, 1'b1, 1'b1);
        expect_st("R4 select pulse restarts", 1'b0, 8'h00, 1'b0);
        cycles(3, 1'b1, 1'b0);
        expect_st("R4 arms after fresh count", 1'b0, 8'h00, 1'b1);

        wait_clks(80);
        expect_st("R10 idle again", 1'b0, 8'h00, 1'b0);

        // window restart: clock toggles alone, then strobe alone
        cycles(12, 1'b0, 1'b1);
        for (int k = 0; k < 10; k++) begin
            rnw_r = ~rnw_r;
            wait_clks(2);
        end
        addr_r = addr_r + 1'b1;
        wait_clks(8);
        expect_st("R7 window discarded clock count", 1'b0, 8'h00, 1'b0);
        cycles(2, 1'b0, 1'b0);
        expect_st("R7 arms after recount", 1'b0, 8'h00, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule